// File: doc/BRIEF.md
# Pipelined Zero-Turnaround Synchronous SRAM

This block is a synthesizable behavioural model of a small synchronous static RAM. Reads and writes can follow each other on every clock with no idle cycle between them. Every input is captured on the rising clock edge. A command then moves through a two-stage pipeline, and read data and write data both use that bus slot two edges after the command's address edge. By default the array holds 256 words of 36 bits, split into four 9-bit lanes that can each be written on their own.

Each cycle the host either loads a new address and command (advance low) or steps a 2-bit burst counter (advance high). A burst step keeps the upper address bits and the command type of the last load. A mode input picks the step order: linear (counting up, wrapping within four) or interleaved (start XOR count). A stall input freezes the whole block. Three enables of mixed polarity must all be active for a load to select the array; any other combination loads a deselect. Data uses separate in and out buses, with an output-enable that a wrapper turns into a shared bidirectional bus.

Top module: `sram_nowait`

## Requirements
- R1: A read loaded at edge N drives its word on `dq_out` with `dq_oe` high in the cycle after edge N+2.
- R2: While `hold` is 1 at an edge, every input is ignored at that edge and all pipeline state, including `dq_out` and `dq_oe`, keeps its value.
- R3: At an edge with `adv` = 0 a new address and command are loaded. With `adv` = 1 the burst counter steps, the upper address bits (all but the low two) stay as loaded, and the command type of the last load (read, write or deselect) repeats.
- R4: With `burst_il` = 0, the k-th step after a load at low bits s uses low address bits (s + k) mod 4.
- R5: With `burst_il` = 1, the k-th step after a load at low bits s uses low address bits s XOR k.
- R6: A write loaded at edge N (`wr_n` = 0) takes its data from `dq_in` at edge N+2 and stores it, with no extra host cycles.
- R7: `lane_we_n[i]` = 0 (sampled with the address) writes bits [9i+8:9i]. Lanes with `lane_we_n[i]` = 1 keep their old contents.
- R8: Reads and writes can be mixed on consecutive cycles in any order. A read that follows a write to the same address returns the new data, merged lane by lane with the older contents.
- R9: The array is selected only when `en_a_n` = 0, `en_b` = 1 and `en_c_n` = 0 at a load. Otherwise the load is a deselect, which writes nothing and never drives the bus.
- R10: `dq_oe` is 0 after reset and in write-data and deselect cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| hold | input | 1 | 1 = suspend: inputs ignored, state frozen |
| adv | input | 1 | 0 = load new address and command, 1 = step burst |
| addr | input | 8 | Word address |
| wr_n | input | 1 | 0 = write, 1 = read (at a load) |
| lane_we_n | input | 4 | Active-low per-lane write enables |
| en_a_n | input | 1 | Enable, active low |
| en_b | input | 1 | Enable, active high |
| en_c_n | input | 1 | Enable, active low |
| burst_il | input | 1 | 1 = interleaved, 0 = linear burst order |
| dq_in | input | 36 | Write data from the bus |
| dq_out | output | 36 | Read data to the bus |
| dq_oe | output | 1 | Bus drive enable |

## Verification
The bench goes after a read placed right after a write to the same word. A design that committed the write late without forwarding it would return the stale word. It runs bursts from every start offset in both orders: a counter that did not wrap, or that mixed up the two orders, would read the wrong words. It inserts stalls in the middle of bursts and pipelines, where a block that let anything advance would lose or duplicate a data slot. It also tries each failing enable combination, where a partial decode would write memory or drive the bus on a deselect.

// File: rtl/nw_sram_pkg.sv
// Shared types and helpers for the zero-turnaround SRAM.
// Assumes: burst wraps within a group of four words.
package nw_sram_pkg;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } op_e;

    // Low two address bits for burst step cnt from start, in the chosen order.
    function automatic logic [1:0] burst_low(input logic [1:0] start,
                                             input logic [1:0] cnt,
                                             input logic       il);
        return il ? (start ^ cnt) : (start + cnt);
    endfunction

endpackage

// File: rtl/nw_addr_gen.sv
// Stage-one register and burst counter.
// Captures each cycle's command or steps the burst from the last loaded base.
// Assumes: ADDR_W >= 3; enables are decoded into `selected` by the parent.
module nw_addr_gen
    import nw_sram_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int LANES  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hold,
    input  logic              adv,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              wr_n,
    input  logic              selected,
    input  logic [LANES-1:0]  lane_we_n,
    input  logic              il,
    output op_e               op1,
    output logic [ADDR_W-1:0] addr1,
    output logic [LANES-1:0]  mask1
);

    logic [ADDR_W-1:0] base_q;
    logic [1:0]        cnt_q;
    logic [1:0]        cnt_nxt;

    // Next burst count.
    always_comb cnt_nxt = cnt_q + 2'd1;

    // Load or step the stage-one command.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op1    <= OP_IDLE;
            addr1  <= '0;
            mask1  <= '0;
            base_q <= '0;
            cnt_q  <= '0;
        end else if (!hold) begin
            mask1 <= ~lane_we_n;
            if (!adv) begin
                base_q <= addr_in;
                cnt_q  <= 2'd0;
                addr1  <= addr_in;
                op1    <= !selected ? OP_IDLE : (wr_n ? OP_READ : OP_WRITE);
            end else begin
                cnt_q <= cnt_nxt;
                addr1 <= {base_q[ADDR_W-1:2], burst_low(base_q[1:0], cnt_nxt, il)};
            end
        end
    end

endmodule

// File: rtl/nw_array.sv
// Storage array with a one-entry posted write buffer.
// A write is parked in the buffer at its data edge and moved into the array
// at the next write; reads merge the buffer lane by lane on an address hit.
// Assumes: DATA_W divisible by LANES.
module nw_array
    import nw_sram_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 36,
    parameter int LANES  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hold,
    input  op_e               op2,
    input  logic [ADDR_W-1:0] addr2,
    input  logic [LANES-1:0]  mask2,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              oe
);

    localparam int LW    = DATA_W / LANES;
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];
    logic              pv;
    logic [ADDR_W-1:0] pa;
    logic [DATA_W-1:0] pd;
    logic [LANES-1:0]  pm;
    logic [DATA_W-1:0] mem_word;
    logic [DATA_W-1:0] rd_word;
    logic              hit;

    // Array word and posted-entry hit for the stage-two address.
    always_comb begin
        mem_word = mem[addr2];
        hit      = pv && (pa == addr2);
    end

    // Lane-wise forward of the posted write.
    for (genvar g = 0; g < LANES; g++) begin : g_merge
        assign rd_word[g*LW +: LW] = (hit && pm[g]) ? pd[g*LW +: LW]
                                                    : mem_word[g*LW +: LW];
    end

    // Retire the posted entry into the array when a new write arrives.
    always_ff @(posedge clk) begin
        if (rst_n && !hold && op2 == OP_WRITE && pv) begin
            for (int i = 0; i < LANES; i++) begin
                if (pm[i]) mem[pa][i*LW +: LW] <= pd[i*LW +: LW];
            end
        end
    end

    // Posted buffer capture and output register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pv    <= 1'b0;
            pa    <= '0;
            pd    <= '0;
            pm    <= '0;
            rdata <= '0;
            oe    <= 1'b0;
        end else if (!hold) begin
            oe <= (op2 == OP_READ);
            if (op2 == OP_READ) rdata <= rd_word;
            if (op2 == OP_WRITE) begin
                pv <= 1'b1;
                pa <= addr2;
                pd <= wdata;
                pm <= mask2;
            end
        end
    end

endmodule

// File: rtl/sram_nowait.sv
// Top of the zero-turnaround synchronous SRAM.
// Stage one: command capture and burst stepping. Stage two: command delay.
// Data edge: read out or write capture, two edges after the address edge.
// Assumes: synchronous active-low reset; `hold` freezes every register.
module sram_nowait
    import nw_sram_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 36,
    parameter int LANES  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hold,
    input  logic              adv,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_n,
    input  logic [LANES-1:0]  lane_we_n,
    input  logic              en_a_n,
    input  logic              en_b,
    input  logic              en_c_n,
    input  logic              burst_il,
    input  logic [DATA_W-1:0] dq_in,
    output logic [DATA_W-1:0] dq_out,
    output logic              dq_oe
);

    logic              selected;
    op_e               op1;
    logic [ADDR_W-1:0] addr1;
    logic [LANES-1:0]  mask1;
    op_e               op2;
    logic [ADDR_W-1:0] addr2;
    logic [LANES-1:0]  mask2;

    // All three enables must be active to select the array.
    always_comb selected = !en_a_n && en_b && !en_c_n;

    nw_addr_gen #(.ADDR_W(ADDR_W), .LANES(LANES)) u_gen (
        .clk      (clk),
        .rst_n    (rst_n),
        .hold     (hold),
        .adv      (adv),
        .addr_in  (addr),
        .wr_n     (wr_n),
        .selected (selected),
        .lane_we_n(lane_we_n),
        .il       (burst_il),
        .op1      (op1),
        .addr1    (addr1),
        .mask1    (mask1)
    );

    // Stage-two delay so data lines up two edges after the address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op2   <= OP_IDLE;
            addr2 <= '0;
            mask2 <= '0;
        end else if (!hold) begin
            op2   <= op1;
            addr2 <= addr1;
            mask2 <= mask1;
        end
    end

    nw_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LANES(LANES)) u_arr (
        .clk  (clk),
        .rst_n(rst_n),
        .hold (hold),
        .op2  (op2),
        .addr2(addr2),
        .mask2(mask2),
        .wdata(dq_in),
        .rdata(dq_out),
        .oe   (dq_oe)
    );

endmodule

// File: rtl/nw_sram_chk.sv
// Property checker for sram_nowait, attached by bind.
// Assumes: the internal names op1, addr1 and op2 of the top.
module nw_sram_chk
    import nw_sram_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              hold,
    input logic              adv,
    input op_e               op1,
    input logic [ADDR_W-1:0] addr1,
    input op_e               op2,
    input logic              dq_oe
);

    // A stalled edge changes neither the output enable nor stage one.
    p_hold_freeze_r2: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> ($stable(dq_oe) && $stable(addr1) && $stable(op1)));

    // A read in stage two drives the bus on the next cycle.
    p_read_drives_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold && op2 == OP_READ) |=> dq_oe);

    // A write-data slot never drives the bus.
    p_write_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold && op2 == OP_WRITE) |=> !dq_oe);

    // A deselect slot never drives the bus.
    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold && op2 == OP_IDLE) |=> !dq_oe);

    // A burst step keeps the upper address bits.
    p_burst_upper_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold && adv) |=> (addr1[ADDR_W-1:2] == $past(addr1[ADDR_W-1:2])));

    // A burst step repeats the loaded command type.
    p_burst_op_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold && adv) |=> (op1 == $past(op1)));

endmodule

bind sram_nowait nw_sram_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk  (clk),
    .rst_n(rst_n),
    .hold (hold),
    .adv  (adv),
    .op1  (op1),
    .addr1(addr1),
    .op2  (op2),
    .dq_oe(dq_oe)
);

// File: tb/sim_sram_nowait.sv
// Bench for sram_nowait: behavioural reference model compared every clock.
module sim_sram_nowait;

    typedef struct {
        int         kind;   // 0 deselect, 1 read, 2 write
        int         addr;
        logic [3:0] mask;
    } slot_t;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        hold;
    logic        adv;
    logic [7:0]  addr;
    logic        wr_n;
    logic [3:0]  lane_we_n;
    logic        en_a_n, en_b, en_c_n;
    logic        burst_il;
    logic [35:0] dq_in;
    logic [35:0] dq_out;
    logic        dq_oe;

    int          n_chk  = 0;
    int          n_fail = 0;
    bit          done   = 0;
    string       phase  = "R10";

    logic [35:0] mem [256];
    slot_t       pipe [$];
    logic        exp_oe;
    logic [35:0] exp_data;
    int          b_base, b_cnt, b_op;

    always #10 clk = ~clk;

    sram_nowait u0 (
        .clk(clk), .rst_n(rst_n), .hold(hold), .adv(adv), .addr(addr),
        .wr_n(wr_n), .lane_we_n(lane_we_n), .en_a_n(en_a_n), .en_b(en_b),
        .en_c_n(en_c_n), .burst_il(burst_il), .dq_in(dq_in),
        .dq_out(dq_out), .dq_oe(dq_oe)
    );

    // Reference model: retire the oldest slot, then enqueue this edge's command.
    always @(posedge clk) begin
        if (!rst_n) begin
            pipe.delete();
            for (int i = 0; i < 2; i++) pipe.push_back('{0, 0, 4'b0});
            exp_oe = 1'b0;
            b_base = 0; b_cnt = 0; b_op = 0;
        end else if (!hold) begin
            slot_t s, n;
            int    low;
            s = pipe.pop_front();
            if (s.kind == 1) begin
                exp_oe = 1'b1;
                exp_data = mem[s.addr];
            end else begin
                exp_oe = 1'b0;
                if (s.kind == 2)
                    for (int l = 0; l < 4; l++)
                        if (s.mask[l]) mem[s.addr][l*9 +: 9] = dq_in[l*9 +: 9];
            end
            if (!adv) begin
                b_base = int'(addr); b_cnt = 0;
                b_op = (!en_a_n && en_b && !en_c_n) ? (wr_n ? 1 : 2) : 0;
                n.addr = b_base;
            end else begin
                b_cnt = (b_cnt + 1) % 4;
                low = burst_il ? ((b_base % 4) ^ b_cnt) : (((b_base % 4) + b_cnt) % 4);
                n.addr = (b_base / 4) * 4 + low;
            end
            n.kind = b_op;
            n.mask = ~lane_we_n;
            pipe.push_back(n);
        end
    end

    // Compare every clock, away from the active edge.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            n_chk++;
            if (dq_oe !== exp_oe || (exp_oe && dq_out !== exp_data)) begin
                n_fail++;
                $display("FAIL %s: oe=%b data=%h expected oe=%b data=%h",
                         phase, dq_oe, dq_out, exp_oe, exp_data);
            end
        end
    end

    task automatic cyc(input logic a, input logic [7:0] ad, input logic w_n,
                       input logic [3:0] ln, input logic [2:0] en,
                       input logic il, input logic h);
        @(negedge clk);
        adv = a; addr = ad; wr_n = w_n; lane_we_n = ln;
        {en_a_n, en_b, en_c_n} = en; burst_il = il; hold = h;
        dq_in = {$urandom, $urandom};
    endtask

    localparam logic [2:0] SEL = 3'b010;

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_fail++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; hold = 0; adv = 0; addr = 0; wr_n = 1; lane_we_n = 4'hF;
        en_a_n = 1; en_b = 0; en_c_n = 1; burst_il = 0; dq_in = '0;
        for (int i = 0; i < 256; i++) mem[i] = '0;
        repeat (3) @(negedge clk);
        // R10: output enable low during reset.
        n_chk++;
        if (dq_oe !== 1'b0) begin
            n_fail++;
            $display("FAIL R10: oe=%b expected oe=0 in reset", dq_oe);
        end
        rst_n = 1'b1;

        // R6: fill every word with full-lane writes.
        phase = "R6";
        for (int i = 0; i < 256; i++) cyc(0, 8'(i), 0, 4'h0, SEL, 0, 0);

        // R1: single reads at scattered addresses.
        phase = "R1";
        for (int i = 0; i < 16; i++) cyc(0, 8'(i * 17), 1, 4'hF, SEL, 0, 0);

        // R4: linear read and write bursts from every start offset.
        phase = "R4";
        for (int s = 0; s < 4; s++) begin
            cyc(0, 8'(8'h40 + s), 1, 4'hF, SEL, 0, 0);
            for (int k = 0; k < 3; k++) cyc(1, 8'h00, 1, 4'hF, SEL, 0, 0);
            cyc(0, 8'(8'h50 + s), 0, 4'h0, SEL, 0, 0);
            for (int k = 0; k < 3; k++) cyc(1, 8'h00, 0, 4'h0, SEL, 0, 0);
        end

        // R5: interleaved bursts, read and write.
        phase = "R5";
        for (int s = 0; s < 4; s++) begin
            cyc(0, 8'(8'h80 + s), 0, 4'h0, SEL, 1, 0);
            for (int k = 0; k < 3; k++) cyc(1, 8'h00, 0, 4'h0, SEL, 1, 0);
            cyc(0, 8'(8'h80 + s), 1, 4'hF, SEL, 1, 0);
            for (int k = 0; k < 5; k++) cyc(1, 8'h00, 1, 4'hF, SEL, 1, 0);
        end

        // R7: single-lane and mixed-lane writes, each read back.
        phase = "R7";
        for (int m = 0; m < 16; m++) begin
            cyc(0, 8'(8'hA0 + m), 0, 4'(m), SEL, 0, 0);
            cyc(0, 8'(8'hA0 + m), 1, 4'hF, SEL, 0, 0);
        end

        // R8: alternating write/read on the same and nearby words.
        phase = "R8";
        for (int i = 0; i < 24; i++) begin
            cyc(0, 8'(8'hC0 + (i % 3)), 0, 4'(i % 16), SEL, 0, 0);
            cyc(0, 8'(8'hC0 + (i % 3)), 1, 4'hF, SEL, 0, 0);
            cyc(0, 8'(8'hC0 + (i % 3)), 1, 4'hF, SEL, 0, 0);
        end

        // R9: every non-selecting enable combination, writes then reads.
        phase = "R9";
        for (int e = 0; e < 8; e++) begin
            if (3'(e) != SEL) begin
                cyc(0, 8'h10, 0, 4'h0, 3'(e), 0, 0);
                cyc(1, 8'h00, 0, 4'h0, 3'(e), 0, 0);
                cyc(0, 8'h10, 1, 4'hF, 3'(e), 0, 0);
            end
        end
        cyc(0, 8'h10, 1, 4'hF, SEL, 0, 0);
        cyc(1, 8'h00, 1, 4'hF, SEL, 0, 0);

        // R2: stalls inside bursts and mixed pipelines, with inputs toggling.
        phase = "R2";
        for (int i = 0; i < 20; i++) begin
            cyc(0, 8'(i * 11), i[0], 4'(i), SEL, i[1], 0);
            cyc(1, 8'hFF, ~i[0], 4'h0, 3'b101, ~i[1], 1);
            cyc(1, 8'h00, i[0], 4'(i), SEL, i[1], 0);
            cyc(0, 8'hFF, 0, 4'h0, SEL, 0, 1);
            cyc(1, 8'h00, i[0], 4'(i), SEL, i[1], 0);
        end

        // R3: random mix of loads, steps, stalls and deselects.
        phase = "R3";
        for (int i = 0; i < 3000; i++) begin
            logic [2:0] en;
            en = ($urandom % 4 == 0) ? 3'($urandom) : SEL;
            cyc(1'($urandom), 8'($urandom), 1'($urandom), 4'($urandom), en,
                1'($urandom), ($urandom % 10) == 0);
        end

        for (int i = 0; i < 4; i++) cyc(1, 8'h00, 1, 4'hF, 3'b101, 0, 0);
        @(negedge clk);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule